// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the programmable register file of an I/O interrupt controller. Software reaches it through two locations on a simple 32-bit register bus. The first holds an 8-bit index. The second is a data window onto whichever internal register that index selects. Behind the window are a 4-bit controller identifier, a read-only version word, an arbitration word, and a table of 64-bit redirection entries, one for each interrupt pin. Each entry is reached as two 32-bit halves.

Every field of every entry is exported as a flat output vector. Interrupt delivery logic next to this block reads those fields to route each pin. That delivery logic, and the end-of-interrupt logic, report the remote-IRR state of level pins back through set and clear inputs. The bus can never write remote-IRR or delivery status. The only exception is the hardware rule that an entry left in edge mode by a write has its remote-IRR forced to zero. Whenever a write flips an entry's mask bit, the block emits a one-cycle pulse that carries the pin number, so that mask listeners can follow the change.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset the index reads 0, the identifier is 0, and every entry has its mask bit (bit 16 of the low half) set. All other entry fields are 0.
- R2: A write to bus offset 0x00 stores data bits 7:0 as the index, and a read of offset 0x00 returns the index zero-extended to 32 bits.
- R3: With index 0, window writes store data bits 27:24 as the identifier, and window reads return it in bits 27:24 with every other bit zero. With index 2, window reads return the same word and window writes change nothing.
- R4: With index 1, window reads return (PINS-1) in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes to index 1 change nothing.
- R5: Entry n sits at index 0x10+2n for the low half and 0x11+2n for the high half. A window write replaces only the selected half. The low half is laid out as vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger mode 15 (1 = level, 0 = edge) and mask 16. The high half carries the destination in bits 31:24. Reserved bits read as zero.
- R6: A window read at index 3 to 0x0F, or at an entry index whose entry number is PINS or more, returns all ones. Window writes to those indexes change no state.
- R7: A window write never changes the delivery-status or remote-IRR bit of the entry it targets, except as R8 states.
- R8: If an entry's trigger mode is edge after a window write to it, that entry's remote-IRR is 0.
- R9: A pulse on rirr_set[p] sets remote-IRR of entry p only when that entry is in level mode. A pulse on rirr_clr[p] clears it. If both pulse in the same cycle, the set wins.
- R10: When a window write changes an entry's mask bit, mask_chg_pulse is high for exactly the following cycle and mask_chg_pin holds that entry number. Writes that leave the mask unchanged give no pulse.
- R11: Bus reads at offsets other than 0x00 and 0x10 return zero, and writes to them change no state. bus_rdata is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset: 0x00 index, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, same cycle |
| rirr_set | input | PINS | Per-pin remote-IRR set from delivery logic |
| rirr_clr | input | PINS | Per-pin remote-IRR clear from end-of-interrupt logic |
| ent_vector | output | 8*PINS | Vector of each entry |
| ent_dlv_mode | output | 3*PINS | Delivery mode of each entry |
| ent_dest_mode | output | PINS | Destination mode of each entry |
| ent_dlv_status | output | PINS | Delivery status of each entry |
| ent_polarity | output | PINS | Pin polarity of each entry |
| ent_remote_irr | output | PINS | Remote-IRR of each entry |
| ent_trig | output | PINS | Trigger mode of each entry, 1 = level |
| ent_mask | output | PINS | Mask of each entry |
| ent_dest | output | 8*PINS | Destination of each entry |
| mask_chg_pulse | output | 1 | One-cycle mask change strobe |
| mask_chg_pin | output | clog2(PINS) | Entry whose mask changed |

## Verification
The properties assume that a bus access lasts one cycle with bus_en high, and that rirr_set reaches a pin only through delivery logic that honours trigger mode. The edge-mode invariant on remote-IRR holds because the entry ignores a set while the pin is in edge mode. The stimulus drives one access per cycle from negative clock edges and pulses the remote-IRR inputs on both edge and level pins. It also walks the index through the identifier, the version word, the gap of unused indexes, the last valid entry and the first index past the table.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   localparam int IDW    = 4;
   localparam int DATA_W = 32;

   localparam logic [7:0] OFS_INDEX  = 8'h00;
   localparam logic [7:0] OFS_WINDOW = 8'h10;

   localparam logic [7:0] IDX_IDENT = 8'h00;
   localparam logic [7:0] IDX_VER   = 8'h01;
   localparam logic [7:0] IDX_ARB   = 8'h02;
   localparam logic [7:0] IDX_TABLE = 8'h10;

   // low-half bit positions that software controls
   localparam int B_DLV_LO = 8;
   localparam int B_DMODE  = 11;
   localparam int B_POL    = 13;
   localparam int B_TRIG   = 15;
   localparam int B_MASK   = 16;

   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       trig;
      logic       rirr;
      logic       pol;
      logic       dstat;
      logic       dmode;
      logic [2:0] dlv;
      logic [7:0] vector;
   } redir_t;

   localparam redir_t REDIR_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                    rirr: 1'b0, pol: 1'b0, dstat: 1'b0,
                                    dmode: 1'b0, dlv: 3'b000, vector: 8'h00};

   function automatic logic [DATA_W-1:0] lo_word(input redir_t e);
      return {15'b0, e.mask, e.trig, e.rirr, e.pol, e.dstat,
              e.dmode, e.dlv, e.vector};
   endfunction

   function automatic logic [DATA_W-1:0] hi_word(input redir_t e);
      return {e.dest, 24'b0};
   endfunction

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
   import irq_redir_pkg::*;
#(
   parameter int PINS  = 24,
   parameter int PIN_W = 5
) (
   input  logic [7:0]       idx,
   output logic             hit_ident,
   output logic             hit_ver,
   output logic             hit_arb,
   output logic             hit_entry,
   output logic             hi_half,
   output logic [PIN_W-1:0] pin
);

   localparam logic [6:0] PINS_L = 7'(PINS);

   logic [7:0] rel;
   logic [6:0] slot;

   always_comb begin
      rel       = idx - IDX_TABLE;
      slot      = rel[7:1];
      hit_ident = (idx == IDX_IDENT);
      hit_ver   = (idx == IDX_VER);
      hit_arb   = (idx == IDX_ARB);
      hit_entry = (idx >= IDX_TABLE) && (slot < PINS_L);
      hi_half   = idx[0];
      pin       = PIN_W'(slot);
   end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
   import irq_redir_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rirr_set,
   input  logic              rirr_clr,
   output redir_t            q,
   output logic              mask_flip
);

   redir_t nxt;

   always_comb begin
      nxt = q;
      if (wr_lo) begin
         nxt.vector = wdata[7:0];
         nxt.dlv    = wdata[B_DLV_LO+2:B_DLV_LO];
         nxt.dmode  = wdata[B_DMODE];
         nxt.pol    = wdata[B_POL];
         nxt.trig   = wdata[B_TRIG];
         nxt.mask   = wdata[B_MASK];
      end
      if (wr_hi)
         nxt.dest = wdata[31:24];
      // remote-IRR follows the delivery side; set only counts in level mode
      if (rirr_set && q.trig)
         nxt.rirr = 1'b1;
      else if (rirr_clr)
         nxt.rirr = 1'b0;
      // an entry left in edge mode by a write drops remote-IRR
      if ((wr_lo || wr_hi) && !nxt.trig)
         nxt.rirr = 1'b0;
   end

   assign mask_flip = wr_lo && (wdata[B_MASK] != q.mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= REDIR_RST;
      else        q <= nxt;
   end

endmodule

// File: rtl/irq_redir_rdmux.sv
module irq_redir_rdmux
   import irq_redir_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter int         PIN_W   = 5,
   parameter logic [7:0] VERSION = 8'h20
) (
   input  logic                  hit_ident,
   input  logic                  hit_ver,
   input  logic                  hit_arb,
   input  logic                  hit_entry,
   input  logic                  hi_half,
   input  logic [PIN_W-1:0]      pin,
   input  redir_t [PINS-1:0]     tbl,
   input  logic [IDW-1:0]        ident,
   output logic [DATA_W-1:0]     win
);

   localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

   redir_t sel;

   always_comb begin
      sel = tbl[pin];
      if (hit_ident || hit_arb)
         win = {4'b0, ident, 24'b0};
      else if (hit_ver)
         win = {8'h00, MAX_PIN, 8'h00, VERSION};
      else if (hit_entry)
         win = hi_half ? hi_word(sel) : lo_word(sel);
      else
         win = '1;
   end

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
   import irq_redir_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter logic [7:0] VERSION = 8'h20,
   localparam int        PIN_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [7:0]            bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [PINS-1:0]       rirr_set,
   input  logic [PINS-1:0]       rirr_clr,
   output logic [PINS*8-1:0]     ent_vector,
   output logic [PINS*3-1:0]     ent_dlv_mode,
   output logic [PINS-1:0]       ent_dest_mode,
   output logic [PINS-1:0]       ent_dlv_status,
   output logic [PINS-1:0]       ent_polarity,
   output logic [PINS-1:0]       ent_remote_irr,
   output logic [PINS-1:0]       ent_trig,
   output logic [PINS-1:0]       ent_mask,
   output logic [PINS*8-1:0]     ent_dest,
   output logic                  mask_chg_pulse,
   output logic [PIN_W-1:0]      mask_chg_pin
);

   // elaboration-time parameter checks
   if (PINS < 1 || PINS > 120) begin : g_bad_pins
      $error("PINS must lie in 1..120 so the table fits an 8-bit index");
   end

   logic [7:0]       idx_q;
   logic [IDW-1:0]   ident_q;
   logic             wr_index, wr_win, rd_req;
   logic             hit_ident, hit_ver, hit_arb, hit_entry, hi_half;
   logic [PIN_W-1:0] pin;
   redir_t [PINS-1:0] tbl;
   logic [PINS-1:0]  flips;
   logic [31:0]      win;

   assign wr_index = bus_en &&  bus_we && (bus_addr == OFS_INDEX);
   assign wr_win   = bus_en &&  bus_we && (bus_addr == OFS_WINDOW);
   assign rd_req   = bus_en && !bus_we;

   irq_redir_decode #(.PINS(PINS), .PIN_W(PIN_W)) u_dec (
      .idx       (idx_q),
      .hit_ident (hit_ident),
      .hit_ver   (hit_ver),
      .hit_arb   (hit_arb),
      .hit_entry (hit_entry),
      .hi_half   (hi_half),
      .pin       (pin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= 8'h00;
      else if (wr_index) idx_q <= bus_wdata[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ident_q <= '0;
      else if (wr_win && hit_ident)  ident_q <= bus_wdata[27:24];
   end

   for (genvar p = 0; p < PINS; p++) begin : g_ent
      logic wr_lo, wr_hi;
      assign wr_lo = wr_win && hit_entry && !hi_half && (pin == PIN_W'(p));
      assign wr_hi = wr_win && hit_entry &&  hi_half && (pin == PIN_W'(p));

      irq_redir_entry u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_lo     (wr_lo),
         .wr_hi     (wr_hi),
         .wdata     (bus_wdata),
         .rirr_set  (rirr_set[p]),
         .rirr_clr  (rirr_clr[p]),
         .q         (tbl[p]),
         .mask_flip (flips[p])
      );

      assign ent_vector[p*8 +: 8]   = tbl[p].vector;
      assign ent_dlv_mode[p*3 +: 3] = tbl[p].dlv;
      assign ent_dest_mode[p]       = tbl[p].dmode;
      assign ent_dlv_status[p]      = tbl[p].dstat;
      assign ent_polarity[p]        = tbl[p].pol;
      assign ent_remote_irr[p]      = tbl[p].rirr;
      assign ent_trig[p]            = tbl[p].trig;
      assign ent_mask[p]            = tbl[p].mask;
      assign ent_dest[p*8 +: 8]     = tbl[p].dest;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_chg_pulse <= 1'b0;
         mask_chg_pin   <= '0;
      end else begin
         mask_chg_pulse <= |flips;
         if (|flips) mask_chg_pin <= pin;
      end
   end

   irq_redir_rdmux #(.PINS(PINS), .PIN_W(PIN_W), .VERSION(VERSION)) u_rd (
      .hit_ident (hit_ident),
      .hit_ver   (hit_ver),
      .hit_arb   (hit_arb),
      .hit_entry (hit_entry),
      .hi_half   (hi_half),
      .pin       (pin),
      .tbl       (tbl),
      .ident     (ident_q),
      .win       (win)
   );

   always_comb begin
      bus_rdata = 32'h0;
      if (rd_req) begin
         if (bus_addr == OFS_INDEX)       bus_rdata = {24'h0, idx_q};
         else if (bus_addr == OFS_WINDOW) bus_rdata = win;
      end
   end

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
   parameter int         PINS    = 24,
   parameter logic [7:0] VERSION = 8'h20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_en,
   input logic            bus_we,
   input logic [7:0]      bus_addr,
   input logic [31:0]     bus_wdata,
   input logic [31:0]     bus_rdata,
   input logic [7:0]      idx_q,
   input logic [PINS-1:0] ent_trig,
   input logic [PINS-1:0] ent_remote_irr,
   input logic            mask_chg_pulse
);

   localparam logic [8:0] END_IDX = 9'(16 + 2 * PINS);

   // R2
   index_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == 8'h00) |=> (idx_q == $past(bus_wdata[7:0])));

   // R4
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == 8'h10 && idx_q == 8'h01)
         |-> (bus_rdata == {8'h00, 8'(PINS - 1), 8'h00, VERSION}));

   // R6
   out_of_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == 8'h10 && {1'b0, idx_q} >= END_IDX)
         |-> (bus_rdata == 32'hFFFF_FFFF));

   // R11
   other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr != 8'h00 && bus_addr != 8'h10)
         |-> (bus_rdata == 32'h0));

   // R10
   mask_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_pulse |-> $past(bus_en && bus_we && bus_addr == 8'h10));

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      // R8
      edge_rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ent_trig[p] |-> !ent_remote_irr[p]);
   end

endmodule

bind irq_redir_regs irq_redir_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_en         (bus_en),
   .bus_we         (bus_we),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .idx_q          (idx_q),
   .ent_trig       (ent_trig),
   .ent_remote_irr (ent_remote_irr),
   .mask_chg_pulse (mask_chg_pulse)
);

// File: tb/irq_redir_regs_tb.sv
`timescale 1ns/100ps
module irq_redir_regs_tb;

   localparam int PINS  = 24;
   localparam int PIN_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [PINS-1:0]   rirr_set = '0, rirr_clr = '0;
   logic [PINS*8-1:0] ent_vector, ent_dest;
   logic [PINS*3-1:0] ent_dlv_mode;
   logic [PINS-1:0]   ent_dest_mode, ent_dlv_status, ent_polarity;
   logic [PINS-1:0]   ent_remote_irr, ent_trig, ent_mask;
   logic              mask_chg_pulse;
   logic [PIN_W-1:0]  mask_chg_pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_redir_regs #(.PINS(PINS), .VERSION(8'h20)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rirr_set(rirr_set), .rirr_clr(rirr_clr),
      .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
      .ent_dest_mode(ent_dest_mode), .ent_dlv_status(ent_dlv_status),
      .ent_polarity(ent_polarity), .ent_remote_irr(ent_remote_irr),
      .ent_trig(ent_trig), .ent_mask(ent_mask), .ent_dest(ent_dest),
      .mask_chg_pulse(mask_chg_pulse), .mask_chg_pin(mask_chg_pin)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [31:0] data;   // write data, or expected read data
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 32'h0000_0000, 4'd1},  // R1 index resets to 0
      '{1'b1, 8'h00, 32'h1234_5601, 4'd2},
      '{1'b0, 8'h00, 32'h0000_0001, 4'd2},  // R2 low byte kept
      '{1'b0, 8'h10, 32'h0017_0020, 4'd4},  // R4 version word
      '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd4},
      '{1'b0, 8'h10, 32'h0017_0020, 4'd4},  // R4 write ignored
      '{1'b1, 8'h00, 32'h0000_0000, 4'd3},
      '{1'b1, 8'h10, 32'hA5FF_FFFF, 4'd3},
      '{1'b0, 8'h10, 32'h0500_0000, 4'd3},  // R3 id in 27:24
      '{1'b1, 8'h00, 32'h0000_0002, 4'd3},
      '{1'b0, 8'h10, 32'h0500_0000, 4'd3},  // R3 arbitration reads id
      '{1'b1, 8'h10, 32'h0F00_0000, 4'd3},
      '{1'b1, 8'h00, 32'h0000_0000, 4'd3},
      '{1'b0, 8'h10, 32'h0500_0000, 4'd3},  // R3 arbitration write ignored
      '{1'b1, 8'h00, 32'h0000_0010, 4'd1},
      '{1'b0, 8'h10, 32'h0001_0000, 4'd1},  // R1 entry 0 masked
      '{1'b1, 8'h10, 32'hFFFE_F341, 4'd7},
      '{1'b0, 8'h10, 32'h0000_A341, 4'd7},  // R7 status bits kept, R5 reserved zero
      '{1'b1, 8'h00, 32'h0000_0011, 4'd5},
      '{1'b1, 8'h10, 32'hC3FF_FFFF, 4'd5},
      '{1'b0, 8'h10, 32'hC300_0000, 4'd5},  // R5 high half
      '{1'b1, 8'h00, 32'h0000_0010, 4'd5},
      '{1'b0, 8'h10, 32'h0000_A341, 4'd5},  // R5 low half untouched
      '{1'b1, 8'h00, 32'h0000_0040, 4'd6},
      '{1'b0, 8'h10, 32'hFFFF_FFFF, 4'd6},  // R6 past table
      '{1'b1, 8'h00, 32'h0000_003F, 4'd1},
      '{1'b0, 8'h10, 32'h0000_0000, 4'd1},  // R1 last entry high
      '{1'b1, 8'h00, 32'h0000_003E, 4'd1},
      '{1'b0, 8'h10, 32'h0001_0000, 4'd1},  // R1 last entry low
      '{1'b1, 8'h00, 32'h0000_0005, 4'd6},
      '{1'b0, 8'h10, 32'hFFFF_FFFF, 4'd6},  // R6 unused gap index
      '{1'b0, 8'h08, 32'h0000_0000, 4'd11}, // R11 other offset
      '{1'b0, 8'h14, 32'h0000_0000, 4'd11}  // R11 other offset
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic rd_idx(input logic [7:0] i, output logic [31:0] d);
      wr(8'h00, {24'h0, i});
      rd(8'h10, d);
   endtask

   task automatic pulse_rirr(input int p, input bit s, input bit c);
      @(negedge clk);
      rirr_set[p] = s; rirr_clr[p] = c;
      @(negedge clk);
      rirr_set = '0; rirr_clr = '0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 mask reset", {8'h0, ent_mask}, {8'h0, {PINS{1'b1}}});
      chk("R1 remote reset", {8'h0, ent_remote_irr}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, v);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].data);
         end
      end

      // R9 set in level mode, entry 0 currently level
      pulse_rirr(0, 1'b1, 1'b0);
      chk("R9 level set", {31'h0, ent_remote_irr[0]}, 32'h1);
      rd_idx(8'h10, v);
      chk("R9 readback", v, 32'h0000_E341);
      // R7 level rewrite keeps remote-IRR
      wr(8'h10, 32'h0000_A341);
      rd(8'h10, v);
      chk("R7 keep remote", v, 32'h0000_E341);
      // R8 edge rewrite clears it
      wr(8'h10, 32'h0000_2341);
      rd(8'h10, v);
      chk("R8 edge clears", v, 32'h0000_2341);
      // R9 set ignored in edge mode
      pulse_rirr(0, 1'b1, 1'b0);
      chk("R9 edge ignores set", {31'h0, ent_remote_irr[0]}, 32'h0);
      // R9 clear, and set wins over clear
      wr(8'h10, 32'h0000_A341);
      pulse_rirr(0, 1'b1, 1'b1);
      chk("R9 set beats clear", {31'h0, ent_remote_irr[0]}, 32'h1);
      pulse_rirr(0, 1'b0, 1'b1);
      chk("R9 clear", {31'h0, ent_remote_irr[0]}, 32'h0);

      // R10 mask change pulse on entry 1
      wr(8'h00, 32'h0000_0012);
      wr(8'h10, 32'h0000_0000);
      chk("R10 pulse", {31'h0, mask_chg_pulse}, 32'h1);
      chk("R10 pin", {27'h0, mask_chg_pin}, 32'd1);
      @(posedge clk); #1;
      chk("R10 one cycle", {31'h0, mask_chg_pulse}, 32'h0);
      wr(8'h10, 32'h0000_0033);
      chk("R10 no pulse same mask", {31'h0, mask_chg_pulse}, 32'h0);
      chk("R5 vector port", {24'h0, ent_vector[15:8]}, 32'h33);

      // R6 writes past the table change nothing
      wr(8'h00, 32'h0000_0040);
      wr(8'h10, 32'h0000_0000);
      chk("R6 no pulse", {31'h0, mask_chg_pulse}, 32'h0);
      chk("R6 masks intact", {8'h0, ent_mask}, {8'h0, {PINS{1'b1}} & ~32'h2 & ~32'h1});
      wr(8'h00, 32'h0000_0005);
      wr(8'h10, 32'h0000_0000);
      rd_idx(8'h3E, v);
      chk("R6 last entry intact", v, 32'h0001_0000);

      // R11 writes to other offsets are ignored
      wr(8'h04, 32'h0000_0010);
      rd(8'h00, v);
      chk("R11 index unchanged", v, 32'h0000_003E);

      // R1 reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 masks after reset", {8'h0, ent_mask}, {8'h0, {PINS{1'b1}}});
      chk("R1 dest after reset", ent_dest[31:0], 32'h0);
      rd(8'h00, v);
      chk("R1 index after reset", v, 32'h0);
      rd(8'h10, v);
      chk("R1 id after reset", v, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule